// File: doc/BRIEF.md
# UART Sampling-Rate Generator with Prescaler

This block turns one reference clock into the timing pulses a single UART channel needs. A front-end prescaler passes the reference through unchanged or divides it by four. A 16-bit divisor, written as two separate bytes, then divides the prescaled rate. The result is a one-cycle sampling enable that the transmitter shifter and the receiver sampler use as their oversampling tick. A second counter groups these enables into a one-per-bit strobe. The group is 16 enables long, or 8 long when the channel's fast-oversampling select is set.

The serial bit rate is the reference frequency divided by the prescale factor, the divisor and the oversampling ratio. The same divisor therefore gives twice the bit rate in 8x mode. The divisor bytes have no reset value, so software must write them before the channel is used. Reset clears the running count, and the count stays idle until the next prescaled step loads the programmed value. Everything runs in the reference clock domain. The outputs are enables, not derived clocks.

Top module: `uart_baud_gen`

## Requirements
- R1: While `rst` is high, and in the cycle after it is sampled high, `samp_tick` and `bit_tick` are 0.
- R2: With `pre_div4` = 0 and a divisor D ≥ 1, consecutive `samp_tick` pulses are exactly D clock cycles apart.
- R3: With `pre_div4` = 1 and a divisor D ≥ 1, consecutive `samp_tick` pulses are exactly 4·D clock cycles apart.
- R4: The divisor is {high byte, low byte}. A write with `div_lo_we` sets bits 7:0 and a write with `div_hi_we` sets bits 15:8. Any value from 1 to 65535 is usable.
- R5: A divisor of 0 inhibits the block: no `samp_tick` and no `bit_tick` pulse occurs.
- R6: With `over8` = 0, consecutive `bit_tick` pulses are exactly 16 sampling enables apart.
- R7: With `over8` = 1, consecutive `bit_tick` pulses are exactly 8 sampling enables apart. For the same divisor this is twice the bit rate of R6.
- R8: A divisor write made while an interval is running does not change that interval. The new value governs every interval after the next reload.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset of the counters and outputs |
| div_lo_we | input | 1 | Write strobe for the divisor low byte |
| div_hi_we | input | 1 | Write strobe for the divisor high byte |
| div_wdata | input | 8 | Byte written to the selected divisor half |
| pre_div4 | input | 1 | Prescaler select: 0 passes the reference through, 1 divides it by 4 |
| over8 | input | 1 | Oversampling select: 0 for 16x, 1 for 8x |
| samp_tick | output | 1 | One-cycle oversampling enable |
| samp_tick_unused_guard | output | 1 | Always 0 |
| bit_tick | output | 1 | One-cycle strobe, once per serial bit |

## Verification
The bench measures the spacing between sampling enables at divisor 1, where the enable fires every prescaled step. It also measures divisor 2 and the full-scale divisor 65535. A counter that wraps one step early or late, or that truncates the top bit, shows up there as a spacing that is off by one step or sharply shortened. A mixed divisor of 0x0102 under the divide-by-4 prescaler in 8x mode catches swapped byte lanes and a prescaler that counts the wrong number of steps. A divisor written in the middle of a count must leave the running interval at the old length. A design that loads the counter on the write would shorten that interval. A zero divisor must keep both outputs silent, where a naive down-counter would underflow and tick after 65536 steps.

// File: rtl/brg_pkg.sv
package brg_pkg;
  localparam int unsigned BRG_DIV_W   = 16;
  localparam int unsigned BRG_PRE     = 4;
  localparam int unsigned BRG_OVS_STD = 16;
  localparam int unsigned BRG_OVS_FST = 8;

  function automatic int unsigned ovs_width(input int unsigned ratio);
    return (ratio <= 2) ? 1 : $clog2(ratio);
  endfunction
endpackage

// File: rtl/brg_prescale.sv
module brg_prescale #(
  parameter int unsigned RATIO = brg_pkg::BRG_PRE
) (
  input  logic clk,
  input  logic rst,
  input  logic div_sel_i,
  output logic step_o
);
  localparam int unsigned CW = brg_pkg::ovs_width(RATIO);
  localparam logic [CW-1:0] LAST = CW'(RATIO - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (cnt_q == LAST) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign step_o = div_sel_i ? (cnt_q == LAST) : 1'b1;

  // R3: under division, a step is never followed by another step
  p_pre_gap_r3: assert property (@(posedge clk) disable iff (rst)
    (step_o && div_sel_i) |=> (!step_o || !div_sel_i));
endmodule

// File: rtl/brg_divcount.sv
module brg_divcount #(
  parameter int unsigned W = brg_pkg::BRG_DIV_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         step_i,
  input  logic [W-1:0] load_i,
  output logic         tick_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      tick_o <= 1'b0;
    end else begin
      tick_o <= 1'b0;
      if (step_i) begin
        if (cnt_q == '0) begin
          cnt_q <= load_i;
        end else if (cnt_q == W'(1)) begin
          cnt_q  <= load_i;
          tick_o <= 1'b1;
        end else begin
          cnt_q <= cnt_q - 1'b1;
        end
      end
    end
  end

  // R5: an idle (zero) count never yields a tick
  p_idle_silent_r5: assert property (@(posedge clk) disable iff (rst)
    (cnt_q == '0) |=> !tick_o);
  // R8: the running count moves only on a prescaled step
  p_count_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !step_i |=> $stable(cnt_q));
endmodule

// File: rtl/brg_bitstrobe.sv
module brg_bitstrobe #(
  parameter int unsigned OVS_STD = brg_pkg::BRG_OVS_STD,
  parameter int unsigned OVS_FST = brg_pkg::BRG_OVS_FST
) (
  input  logic clk,
  input  logic rst,
  input  logic samp_i,
  input  logic fast_i,
  output logic bit_o
);
  localparam int unsigned CW = brg_pkg::ovs_width(OVS_STD);
  localparam logic [CW-1:0] LAST_STD = CW'(OVS_STD - 1);
  localparam logic [CW-1:0] LAST_FST = CW'(OVS_FST - 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] last;

  assign last = fast_i ? LAST_FST : LAST_STD;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      bit_o <= 1'b0;
    end else begin
      bit_o <= 1'b0;
      if (samp_i) begin
        if (cnt_q >= last) begin
          cnt_q <= '0;
          bit_o <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  // R6: a bit strobe only ever follows a sampling enable
  p_bit_after_samp_r6: assert property (@(posedge clk) disable iff (rst)
    bit_o |-> $past(samp_i));
  // R7: in fast mode the group count stays inside its shorter range
  p_fast_range_r7: assert property (@(posedge clk) disable iff (rst)
    (fast_i && samp_i) |=> (cnt_q <= LAST_FST));
endmodule

// File: rtl/uart_baud_gen.sv
module uart_baud_gen #(
  parameter int unsigned DIV_W   = brg_pkg::BRG_DIV_W,
  parameter int unsigned PRE     = brg_pkg::BRG_PRE,
  parameter int unsigned OVS_STD = brg_pkg::BRG_OVS_STD,
  parameter int unsigned OVS_FST = brg_pkg::BRG_OVS_FST
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       div_lo_we,
  input  logic       div_hi_we,
  input  logic [7:0] div_wdata,
  input  logic       pre_div4,
  input  logic       over8,
  output logic       samp_tick,
  output logic       samp_tick_unused_guard,
  output logic       bit_tick
);
  localparam int unsigned NLANE = DIV_W / 8;

  logic [DIV_W-1:0] div_q;
  logic [NLANE-1:0] lane_we;
  logic             step;

  assign lane_we = NLANE'({div_hi_we, div_lo_we});
  assign samp_tick_unused_guard = 1'b0;

  // divisor bytes carry no reset value
  for (genvar g = 0; g < NLANE; g++) begin : g_lane
    always_ff @(posedge clk) begin
      if (lane_we[g]) div_q[g*8 +: 8] <= div_wdata;
    end
  end

  brg_prescale #(.RATIO(PRE)) u_pre (
    .clk(clk), .rst(rst), .div_sel_i(pre_div4), .step_o(step)
  );

  brg_divcount #(.W(DIV_W)) u_div (
    .clk(clk), .rst(rst), .step_i(step), .load_i(div_q), .tick_o(samp_tick)
  );

  brg_bitstrobe #(.OVS_STD(OVS_STD), .OVS_FST(OVS_FST)) u_bit (
    .clk(clk), .rst(rst), .samp_i(samp_tick), .fast_i(over8), .bit_o(bit_tick)
  );

  // R1: outputs are quiet the cycle after reset is sampled
  p_reset_quiet_r1: assert property (@(posedge clk)
    rst |=> (!samp_tick && !bit_tick));
endmodule

// File: tb/tb_uart_baud_gen.sv
module tb_uart_baud_gen;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       div_lo_we = 1'b0;
  logic       div_hi_we = 1'b0;
  logic [7:0] div_wdata = 8'h00;
  logic       pre_div4 = 1'b0;
  logic       over8 = 1'b0;
  logic       samp_tick, samp_guard, bit_tick;

  uart_baud_gen dut (
    .clk(clk), .rst(rst), .div_lo_we(div_lo_we), .div_hi_we(div_hi_we),
    .div_wdata(div_wdata), .pre_div4(pre_div4), .over8(over8),
    .samp_tick(samp_tick), .samp_tick_unused_guard(samp_guard),
    .bit_tick(bit_tick)
  );

  always #2.5 clk = ~clk;

  int    n_chk = 0, n_bad = 0;
  int    q_sgap[$], q_bgap[$];
  string q_stag[$], q_btag[$];
  longint cyc = 0, last_s = 0, last_b = 0;
  bit    arm_s = 0, arm_b = 0;
  int    seen_s = 0, seen_b = 0;
  bit    done = 0;

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // monitor: scoreboard comparison of measured spacings
  always @(negedge clk) begin
    cyc++;
    if (rst) begin
      arm_s = 0;
      arm_b = 0;
    end else begin
      if (samp_tick) begin
        seen_s++;
        if (arm_s && q_sgap.size() > 0) begin
          int e;
          string t;
          e = q_sgap.pop_front();
          t = q_stag.pop_front();
          check((cyc - last_s) == e, t, cyc - last_s, e);
        end
        last_s = cyc;
        arm_s = 1;
      end
      if (bit_tick) begin
        seen_b++;
        if (arm_b && q_bgap.size() > 0) begin
          int e;
          string t;
          e = q_bgap.pop_front();
          t = q_btag.pop_front();
          check((cyc - last_b) == e, t, cyc - last_b, e);
        end
        last_b = cyc;
        arm_b = 1;
      end
    end
  end

  task automatic wr(input bit hi, input logic [7:0] v);
    @(negedge clk);
    div_wdata = v;
    div_lo_we = !hi;
    div_hi_we = hi;
    @(negedge clk);
    div_lo_we = 1'b0;
    div_hi_we = 1'b0;
  endtask

  // driver: program, reset the counters, push expected spacings, drain
  task automatic run_cfg(input logic [15:0] d, input bit p4, input bit o8,
                         input int sgap, input int ns, input string ts,
                         input int bgap, input int nb, input string tb);
    @(negedge clk);
    rst = 1'b1;
    pre_div4 = p4;
    over8 = o8;
    wr(1'b0, d[7:0]);
    wr(1'b1, d[15:8]);
    for (int i = 0; i < ns; i++) begin q_sgap.push_back(sgap); q_stag.push_back(ts); end
    for (int i = 0; i < nb; i++) begin q_bgap.push_back(bgap); q_btag.push_back(tb); end
    @(negedge clk);
    rst = 1'b0;
    while (q_sgap.size() + q_bgap.size() > 0) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(!samp_tick && !bit_tick && !samp_guard, "R1 reset outputs", {samp_tick, bit_tick}, 0);

    run_cfg(16'd1, 0, 0, 1, 8, "R2 div1 pre1", 16, 3, "R6 16x div1");
    run_cfg(16'd2, 0, 1, 2, 6, "R2 div2 pre1", 16, 3, "R7 8x div2");
    run_cfg(16'd2, 1, 0, 8, 4, "R3 div2 pre4", 128, 2, "R6 16x div2 pre4");
    run_cfg(16'd1, 1, 1, 4, 4, "R3 div1 pre4", 32, 2, "R7 8x div1 pre4");
    run_cfg(16'h0102, 1, 1, 1032, 2, "R4 div0x0102 pre4", 8256, 1, "R7 8x div258");
    run_cfg(16'hFFFF, 0, 0, 65535, 1, "R4 div65535 pre1", 0, 0, "");

    // R8: mid-interval write keeps the running interval
    @(negedge clk);
    rst = 1'b1;
    pre_div4 = 1'b0;
    over8 = 1'b0;
    wr(1'b0, 8'd10);
    wr(1'b1, 8'd0);
    q_sgap.push_back(10); q_stag.push_back("R8 running interval kept");
    q_sgap.push_back(3);  q_stag.push_back("R8 new divisor applied");
    q_sgap.push_back(3);  q_stag.push_back("R8 new divisor applied");
    @(negedge clk);
    rst = 1'b0;
    while (!arm_s) @(negedge clk);
    @(negedge clk);
    wr(1'b0, 8'd3);
    while (q_sgap.size() > 0) @(negedge clk);

    // R5: zero divisor inhibits both outputs
    @(negedge clk);
    rst = 1'b1;
    wr(1'b0, 8'd0);
    wr(1'b1, 8'd0);
    @(negedge clk);
    rst = 1'b0;
    seen_s = 0;
    seen_b = 0;
    repeat (600) @(negedge clk);
    check(seen_s == 0, "R5 no samp_tick with div0", seen_s, 0);
    check(seen_b == 0, "R5 no bit_tick with div0", seen_b, 0);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule